// File: doc/BRIEF.md
# Four-Master Three-Slave Crossbar Arbiter

This block is the arbitration and routing core of a small on-chip crossbar. Four bus masters (instruction fetch, load/store data, DMA and a network controller) reach three slave ports (code flash, SRAM and the peripheral bridge). Each master presents a request with a 32-bit address, write data, a write strobe and a marker for its final data phase. The top four address bits choose the slave port.

Every slave port has its own arbiter and owner register. An idle port takes one requester and keeps it as owner until that owner's last data phase is accepted. The other requesters wait in the meantime. Each port can work in one of two modes. Fixed priority follows the master number. Round robin rotates the search from the master granted last. A master can raise its own priority for a while with an elevation input. Masters that target different ports are served in the same cycle.

Top module: `xbar_slave_arbiter`

## Requirements
- R1: Address bits [31:28] select the slave port: 0x0 selects port 0 (flash), 0x4 selects port 1 (SRAM), 0xC selects port 2 (peripheral bridge).
- R2: A requesting master whose address bits [31:28] match no port sees `m_err` high in the same cycle and is never granted.
- R3: An idle port that sees a request grants it one clock later. The grant shows on `m_gnt`, and the port outputs carry the owner's address, write data and write strobe, with `s_sel` high.
- R4: A granted master keeps the port until a cycle in which `s_ready` and that master's `m_last` are both high. Other requesters of that port get no grant in the meantime.
- R5: In the cycle after the owner's final phase is accepted, the port has no owner (`s_sel` low). A waiting requester is granted in the cycle after that.
- R6: In fixed mode (`arb_rr` bit low) the requester with the lowest master index wins.
- R7: In round-robin mode (`arb_rr` bit high) the search starts at the master after the one granted last and wraps around. After reset the search starts at master 0. With all four masters requesting continuously, each one is served once every four grants.
- R8: Requesters with `m_elev` high win over requesters without it, in both modes. Among elevated requesters the port's mode rule applies.
- R9: Masters that target different ports are granted in the same cycle, and each port carries its own owner's address.
- R10: A granted master receives its port's `s_rdata` on `m_rdata` and its port's `s_ready` on `m_rdy`.
- R11: While reset is high and right after it, no master is granted and no port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_req | input | 4 | Request, one bit per master |
| m_addr | input | 128 | Address, 32 bits per master, master i at [32i+31:32i] |
| m_wdata | input | 128 | Write data, 32 bits per master |
| m_we | input | 4 | Write strobe per master |
| m_last | input | 4 | Final data phase marker per master |
| m_elev | input | 4 | Temporary priority elevation per master |
| arb_rr | input | 3 | Per-port mode: 0 fixed priority, 1 round robin |
| m_gnt | output | 4 | Grant per master |
| m_rdy | output | 4 | Data phase accepted, per master |
| m_err | output | 4 | Unmapped address flag per master |
| m_rdata | output | 128 | Read data per master |
| s_sel | output | 3 | Port has an owner |
| s_addr | output | 96 | Address per port |
| s_wdata | output | 96 | Write data per port |
| s_we | output | 3 | Write strobe per port |
| s_ready | input | 3 | Data phase accepted by the port |
| s_rdata | input | 96 | Read data per port |

## Verification
Two things can happen in the same cycle: one port finishes its owner's last phase and releases it, while another port grants a different master. The bench sets this up by holding three masters on three different ports at once. It then lets them finish, and separately keeps a second master waiting on a port whose owner is ending its transaction. In each case it checks that the finishing port shows an empty cycle before its next grant, while the other ports keep their owners and route their own addresses and read data.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    parameter int XB_NM  = 4;
    parameter int XB_NS  = 3;
    parameter int XB_AW  = 32;
    parameter int XB_DW  = 32;
    parameter int XB_RW  = 4;

    localparam int XB_MIW = $clog2(XB_NM);
    localparam int XB_SIW = $clog2(XB_NS);

    localparam logic [XB_RW-1:0] XB_REGION [XB_NS] = '{4'h0, 4'h4, 4'hC};

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;

    typedef struct packed {
        logic              valid;
        logic [XB_MIW-1:0] idx;
    } owner_t;

    typedef struct packed {
        logic              hit;
        logic [XB_SIW-1:0] sidx;
    } route_t;

    function automatic route_t decode_region(input logic [XB_RW-1:0] region);
        route_t rt;
        rt = '0;
        for (int s = 0; s < XB_NS; s++) begin
            if (!rt.hit && region == XB_REGION[s]) begin
                rt.hit  = 1'b1;
                rt.sidx = XB_SIW'(s);
            end
        end
        return rt;
    endfunction

    function automatic logic [XB_MIW-1:0] pick_rotating(input logic [XB_NM-1:0] mask,
                                                        input logic [XB_MIW-1:0] start);
        logic [XB_MIW-1:0] res;
        logic              found;
        res   = start;
        found = 1'b0;
        for (int k = 0; k < XB_NM; k++) begin
            int c;
            c = (int'(start) + k) % XB_NM;
            if (!found && mask[c]) begin
                res   = XB_MIW'(c);
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
    import xbar_pkg::*;
#(
    parameter int AW     = XB_AW,
    parameter int NUM_S  = XB_NS
) (
    input  logic             req_i,
    input  logic [AW-1:0]    addr_i,
    output logic [NUM_S-1:0] port_req_o,
    output logic             err_o
);

    route_t route;

    always_comb begin
        route      = decode_region(addr_i[AW-1 -: XB_RW]);
        port_req_o = '0;
        if (req_i && route.hit) begin
            port_req_o[route.sidx] = 1'b1;
        end
        err_o = req_i && !route.hit;
    end

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter
    import xbar_pkg::*;
#(
    parameter int NUM_M = XB_NM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_M-1:0] req_i,
    input  logic [NUM_M-1:0] elev_i,
    input  logic [NUM_M-1:0] last_i,
    input  arb_mode_e        mode_i,
    input  logic             ready_i,
    output owner_t           owner_o
);

    owner_t            own_q;
    logic [XB_MIW-1:0] prev_q;
    logic [NUM_M-1:0]  cand;
    logic [XB_MIW-1:0] start;
    logic [XB_MIW-1:0] win;
    logic              done;

    always_comb begin
        cand  = (|(req_i & elev_i)) ? (req_i & elev_i) : req_i;
        start = (mode_i == ARB_ROUND) ? XB_MIW'((int'(prev_q) + 1) % NUM_M) : '0;
        win   = pick_rotating(cand, start);
        done  = own_q.valid && ready_i && last_i[own_q.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= '0;
            prev_q <= XB_MIW'(NUM_M - 1);
        end else if (done) begin
            own_q.valid <= 1'b0;
        end else if (!own_q.valid && (|req_i)) begin
            own_q.valid <= 1'b1;
            own_q.idx   <= win;
            prev_q      <= win;
        end
    end

    assign owner_o = own_q;

    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (rst)
        (own_q.valid && !done) |=> (own_q.valid && $stable(own_q.idx))); // R4

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
        done |=> !own_q.valid); // R5

    AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(own_q.valid) |-> ((($past(req_i) >> own_q.idx) & NUM_M'(1)) != '0)); // R3

endmodule

// File: rtl/xbar_slave_mux.sv
module xbar_slave_mux
    import xbar_pkg::*;
#(
    parameter int NUM_M = XB_NM,
    parameter int AW    = XB_AW,
    parameter int DW    = XB_DW
) (
    input  owner_t              owner_i,
    input  logic [NUM_M*AW-1:0] m_addr_i,
    input  logic [NUM_M*DW-1:0] m_wdata_i,
    input  logic [NUM_M-1:0]    m_we_i,
    output logic                sel_o,
    output logic [AW-1:0]       addr_o,
    output logic [DW-1:0]       wdata_o,
    output logic                we_o
);

    always_comb begin
        sel_o   = owner_i.valid;
        addr_o  = '0;
        wdata_o = '0;
        we_o    = 1'b0;
        if (owner_i.valid) begin
            addr_o  = m_addr_i[int'(owner_i.idx)*AW +: AW];
            wdata_o = m_wdata_i[int'(owner_i.idx)*DW +: DW];
            we_o    = m_we_i[owner_i.idx];
        end
    end

endmodule

// File: rtl/xbar_slave_arbiter.sv
module xbar_slave_arbiter
    import xbar_pkg::*;
#(
    parameter int NUM_M = XB_NM,
    parameter int NUM_S = XB_NS,
    parameter int AW    = XB_AW,
    parameter int DW    = XB_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_M-1:0]    m_req,
    input  logic [NUM_M*AW-1:0] m_addr,
    input  logic [NUM_M*DW-1:0] m_wdata,
    input  logic [NUM_M-1:0]    m_we,
    input  logic [NUM_M-1:0]    m_last,
    input  logic [NUM_M-1:0]    m_elev,
    input  logic [NUM_S-1:0]    arb_rr,
    output logic [NUM_M-1:0]    m_gnt,
    output logic [NUM_M-1:0]    m_rdy,
    output logic [NUM_M-1:0]    m_err,
    output logic [NUM_M*DW-1:0] m_rdata,
    output logic [NUM_S-1:0]    s_sel,
    output logic [NUM_S*AW-1:0] s_addr,
    output logic [NUM_S*DW-1:0] s_wdata,
    output logic [NUM_S-1:0]    s_we,
    input  logic [NUM_S-1:0]    s_ready,
    input  logic [NUM_S*DW-1:0] s_rdata
);

    logic [NUM_S-1:0] dec_req [NUM_M];
    logic [NUM_M-1:0] port_req [NUM_S];
    owner_t           own [NUM_S];

    for (genvar i = 0; i < NUM_M; i++) begin : g_dec
        xbar_decode #(.AW(AW), .NUM_S(NUM_S)) u_dec (
            .req_i      (m_req[i]),
            .addr_i     (m_addr[i*AW +: AW]),
            .port_req_o (dec_req[i]),
            .err_o      (m_err[i])
        );
    end

    always_comb begin
        for (int j = 0; j < NUM_S; j++) begin
            for (int i = 0; i < NUM_M; i++) begin
                port_req[j][i] = dec_req[i][j];
            end
        end
    end

    for (genvar j = 0; j < NUM_S; j++) begin : g_port
        xbar_arbiter #(.NUM_M(NUM_M)) u_arb (
            .clk     (clk),
            .rst     (rst),
            .req_i   (port_req[j]),
            .elev_i  (m_elev),
            .last_i  (m_last),
            .mode_i  (arb_mode_e'(arb_rr[j])),
            .ready_i (s_ready[j]),
            .owner_o (own[j])
        );

        xbar_slave_mux #(.NUM_M(NUM_M), .AW(AW), .DW(DW)) u_mux (
            .owner_i   (own[j]),
            .m_addr_i  (m_addr),
            .m_wdata_i (m_wdata),
            .m_we_i    (m_we),
            .sel_o     (s_sel[j]),
            .addr_o    (s_addr[j*AW +: AW]),
            .wdata_o   (s_wdata[j*DW +: DW]),
            .we_o      (s_we[j])
        );
    end

    always_comb begin
        m_gnt   = '0;
        m_rdy   = '0;
        m_rdata = '0;
        for (int i = 0; i < NUM_M; i++) begin
            for (int j = 0; j < NUM_S; j++) begin
                if (own[j].valid && int'(own[j].idx) == i) begin
                    m_gnt[i]             = 1'b1;
                    m_rdy[i]             = s_ready[j];
                    m_rdata[i*DW +: DW]  = s_rdata[j*DW +: DW];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_M; i++) begin : g_chk
        AST_NO_UNMAPPED_GRANT: assert property (@(posedge clk) disable iff (rst)
            m_err[i] |-> !m_gnt[i]); // R2
    end

endmodule

// File: tb/tb_xbar_slave_arbiter.sv
module tb_xbar_slave_arbiter;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   m_req, m_we, m_last, m_elev;
    logic [127:0] m_addr, m_wdata;
    logic [2:0]   arb_rr, s_ready;
    logic [95:0]  s_rdata;
    logic [3:0]   m_gnt, m_rdy, m_err;
    logic [127:0] m_rdata;
    logic [2:0]   s_sel, s_we;
    logic [95:0]  s_addr, s_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    xbar_slave_arbiter dut (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_we(m_we), .m_last(m_last), .m_elev(m_elev), .arb_rr(arb_rr),
        .m_gnt(m_gnt), .m_rdy(m_rdy), .m_err(m_err), .m_rdata(m_rdata),
        .s_sel(s_sel), .s_addr(s_addr), .s_wdata(s_wdata), .s_we(s_we),
        .s_ready(s_ready), .s_rdata(s_rdata)
    );

    // {mode, req[3:0], elev[3:0], expected winner[1:0]}, all aimed at port 1
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 4'b1111, 4'b0000, 2'd0},
        {1'b0, 4'b1100, 4'b0000, 2'd2},
        {1'b0, 4'b1010, 4'b1000, 2'd3},
        {1'b0, 4'b1111, 4'b0110, 2'd1},
        {1'b1, 4'b1110, 4'b0000, 2'd1},
        {1'b1, 4'b1000, 4'b0000, 2'd3},
        {1'b1, 4'b0111, 4'b0100, 2'd2},
        {1'b1, 4'b1001, 4'b1001, 2'd0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; m_req = '0; m_we = '0; m_last = '0; m_elev = '0;
        m_addr = '0; m_wdata = '0; arb_rr = '0; s_ready = '1;
        s_rdata = {32'hCC00_0002, 32'hBB00_0001, 32'hAA00_0000};
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_m(input int i, input logic [31:0] addr, input logic last);
        m_req[i]          = 1'b1;
        m_addr[i*32 +: 32] = addr;
        m_wdata[i*32 +: 32] = 32'h5000_0000 + i;
        m_we[i]           = i[0];
        m_last[i]         = last;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        do_reset();
        // R11: reset state
        check(m_gnt == 0 && s_sel == 0 && m_err == 0, "R11", {25'd0, s_sel, m_gnt}, 0);

        // Table: arbitration winners, R6 / R7 / R8
        for (int v = 0; v < 8; v++) begin
            do_reset();
            arb_rr = {3{VEC[v][10]}};
            for (int i = 0; i < 4; i++) if (VEC[v][9-(3-i)]) set_m(i, 32'h4000_0100, 1'b1);
            m_elev = VEC[v][5:2];
            @(posedge clk); @(negedge clk);
            check(m_gnt == (4'b1 << VEC[v][1:0]), VEC[v][10] ? "R7/R8 table" : "R6/R8 table",
                  m_gnt, 4'b1 << VEC[v][1:0]);
        end

        // R1, R3, R9, R10: three masters on three ports at once
        do_reset();
        set_m(0, 32'h0000_0010, 1'b0);
        set_m(1, 32'h4000_0020, 1'b0);
        set_m(2, 32'hC000_0030, 1'b0);
        @(posedge clk); @(negedge clk);
        check(m_gnt == 4'b0111 && s_sel == 3'b111, "R9", {m_gnt, 1'b0, s_sel}, 32'h77);
        check(s_addr[31:0] == 32'h0000_0010, "R1 port0", s_addr[31:0], 32'h0000_0010);
        check(s_addr[63:32] == 32'h4000_0020, "R1 port1", s_addr[63:32], 32'h4000_0020);
        check(s_addr[95:64] == 32'hC000_0030, "R1 port2", s_addr[95:64], 32'hC000_0030);
        check(s_wdata[63:32] == 32'h5000_0001 && s_we == 3'b010, "R3 wdata/we",
              s_wdata[63:32], 32'h5000_0001);
        check(m_rdata[95:64] == 32'hCC00_0002 && m_rdy[2], "R10 rdata", m_rdata[95:64],
              32'hCC00_0002);
        s_ready = 3'b101;
        #1;
        check(m_rdy == 4'b0101, "R10 rdy", m_rdy, 4'b0101);
        // finish port 0 only, ports 1 and 2 must keep owners
        m_last[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        check(m_gnt == 4'b0110 && s_sel == 3'b110, "R5/R9 concurrent release",
              {m_gnt, 1'b0, s_sel}, 32'h66);

        // R2: unmapped address
        do_reset();
        set_m(3, 32'h2000_0000, 1'b1);
        #1;
        check(m_err == 4'b1000, "R2 err", m_err, 4'b1000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(m_gnt == 0 && s_sel == 0, "R2 no grant", {m_gnt, s_sel}, 0);

        // R4, R5: hold and release with a waiting requester
        do_reset();
        set_m(1, 32'h4000_0000, 1'b0);
        @(posedge clk); @(negedge clk);
        set_m(0, 32'h4000_0004, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check(m_gnt == 4'b0010, "R4 hold", m_gnt, 4'b0010);
        end
        m_last[1] = 1'b1;
        @(posedge clk); @(negedge clk);
        m_req[1] = 1'b0;
        check(m_gnt == 0 && s_sel[1] == 1'b0, "R5 gap", {m_gnt, s_sel}, 0);
        @(posedge clk); @(negedge clk);
        check(m_gnt == 4'b0001, "R5 regrant", m_gnt, 4'b0001);

        // R7: rotation with four continuous requesters
        do_reset();
        arb_rr = 3'b010;
        for (int i = 0; i < 4; i++) set_m(i, 32'h4000_0000, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            check(m_gnt == (4'b1 << (k % 4)), "R7 rotation", m_gnt, 4'b1 << (k % 4));
            @(posedge clk); @(negedge clk);
        end

        // R6: fixed mode keeps serving the lowest index
        do_reset();
        for (int i = 0; i < 4; i++) set_m(i, 32'h4000_0000, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check(m_gnt == 4'b0001, "R6 fixed", m_gnt, 4'b0001);
            @(posedge clk); @(negedge clk);
        end

        finish_run();
    end

endmodule